// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This combinational unit settles every condition-dependent decision of a 32-bit RISC core in one place. It compares operand A against either operand B or a 16-bit immediate, under one of six relations, with each relation in either a two's complement (signed) or an unsigned interpretation. One comparator serves both kinds of instruction. In compare mode the verdict becomes a 32-bit value of 0 or 1 for a compare-and-set destination. In branch mode the verdict becomes a taken flag.

The unit also produces the address of the next instruction. The sequential address is the current PC plus 4. A taken branch adds the 16-bit displacement to that address after sign-extending it to 32 bits. Branch mode always compares the two registers, and the immediate port then carries the displacement. Register file access, fetch and pipeline control stay with the surrounding core.

Top module: `cmp_branch_unit`

## Requirements
- R1: `cond` selects the relation of A to the right operand: 0 equal, 1 not equal, 2 greater than, 3 greater or equal, 4 less than, 5 less or equal.
- R2: When `is_signed` is 1, both operands are ordered as two's complement numbers. When it is 0, they are ordered as unsigned numbers. For example, 0x80000000 is less than 0x7FFFFFFF when signed and greater when unsigned.
- R3: In compare mode (`is_branch` = 0), `set_val` is 1 when the relation holds and 0 otherwise, with bits 31..1 always 0. `br_taken` is 0 and `next_pc` is `pc` + 4.
- R4: In compare mode with `use_imm` = 1, the right operand is `imm` rather than `opb`. The immediate is sign-extended to 32 bits when `is_signed` = 1 and zero-extended when `is_signed` = 0.
- R5: In branch mode with the relation holding, `br_taken` is 1 and `next_pc` = `pc` + 4 + sign-extended `imm`, modulo 2^32.
- R6: In branch mode with the relation not holding, `br_taken` is 0 and `next_pc` = `pc` + 4, modulo 2^32.
- R7: In branch mode, `use_imm` has no effect: the right operand is always `opb`. `set_val` is 0 in this mode.
- R8: Condition codes 6 and 7 are invalid. They give `set_val` = 0 and `br_taken` = 0, so `next_pc` is `pc` + 4.
- R9: The unit holds no state. All outputs follow the present inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | Left operand (register A) |
| opb | input | 32 | Right register operand (register B) |
| imm | input | 16 | Compare immediate, or branch displacement in branch mode |
| cond | input | 3 | Relation code |
| is_signed | input | 1 | 1 = two's complement ordering, 0 = unsigned ordering |
| use_imm | input | 1 | Compare against the immediate (compare mode only) |
| is_branch | input | 1 | 1 = branch mode, 0 = compare-and-set mode |
| pc | input | 32 | Address of the current instruction |
| set_val | output | 32 | Compare-and-set result, 0 or 1 |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 32 | Address of the next instruction |

## Verification
Every output of this unit is due in the same cycle as its stimulus, because no register lies between the inputs and `set_val`, `br_taken` or `next_pc`. The bench changes inputs just after a rising edge and samples all three outputs at the following falling edge, half a period later. A behavioural model in the bench uses native signed and unsigned comparisons to compute the expected outputs, and they are compared on every cycle. Stimulus mixes the boundary pairs around zero and the sign bit with random operands, displacements, modes and all eight condition codes.

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int XLEN       = 32,
  parameter int IMMW       = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic [2:0]      cond,
  input  logic            is_signed,
  input  logic            use_imm,
  input  logic            is_branch,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] set_val,
  output logic            br_taken,
  output logic [XLEN-1:0] next_pc
);
  localparam int EXTW = XLEN - IMMW;
  localparam logic [XLEN-1:0] STEP    = INSN_BYTES[XLEN-1:0];
  localparam logic [XLEN-1:0] TOP_BIT = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [2:0] C_EQ = 3'd0, C_NE = 3'd1, C_GT = 3'd2,
                         C_GE = 3'd3, C_LT = 3'd4, C_LE = 3'd5;

  logic [XLEN-1:0] imm_sx, imm_zx, rhs, key_a, key_b, seq_pc;
  logic            same, below, hit;

  assign imm_sx = {{EXTW{imm[IMMW-1]}}, imm};
  assign imm_zx = {{EXTW{1'b0}}, imm};
  assign rhs    = (use_imm && !is_branch) ? (is_signed ? imm_sx : imm_zx) : opb;

  assign key_a  = is_signed ? (opa ^ TOP_BIT) : opa;
  assign key_b  = is_signed ? (rhs ^ TOP_BIT) : rhs;
  assign same   = (key_a == key_b);
  assign below  = (key_a < key_b);

  always_comb begin
    case (cond)
      C_EQ:    hit = same;
      C_NE:    hit = !same;
      C_GT:    hit = !below && !same;
      C_GE:    hit = !below;
      C_LT:    hit = below;
      C_LE:    hit = below || same;
      default: hit = 1'b0;
    endcase
  end

  assign set_val  = {{(XLEN-1){1'b0}}, hit && !is_branch};
  assign br_taken = hit && is_branch;
  assign seq_pc   = pc + STEP;
  assign next_pc  = br_taken ? (seq_pc + imm_sx) : seq_pc;
endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic [IMMW-1:0] imm,
  input logic [2:0]      cond,
  input logic            is_signed,
  input logic            use_imm,
  input logic            is_branch,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] set_val,
  input logic            br_taken,
  input logic [XLEN-1:0] next_pc
);
  logic            known;
  logic [XLEN-1:0] delta, disp;

  assign known = !$isunknown({opa, opb, imm, cond, is_signed, use_imm, is_branch, pc});
  assign delta = next_pc - pc - XLEN'(4);
  assign disp  = XLEN'($signed(imm));

  always_comb begin
    if (known) begin
      a_r3_compare_mode: assert (is_branch || (set_val[XLEN-1:1] == '0 && !br_taken && delta == '0));
      a_r7_branch_no_set: assert (!is_branch || set_val == '0);
      a_r5_taken_target: assert (!br_taken || delta == disp);
      a_r6_fallthrough: assert (br_taken || delta == '0);
      a_r8_invalid_code: assert (cond < 3'd6 || (set_val == '0 && !br_taken));
      a_r1_equal: assert (!(cond == 3'd0 && !use_imm && !is_branch) || set_val[0] == (opa == opb));
      a_r1_not_equal: assert (!(cond == 3'd1 && is_branch) || br_taken == (opa != opb));
    end
  end
endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .opa(opa), .opb(opb), .imm(imm), .cond(cond), .is_signed(is_signed),
  .use_imm(use_imm), .is_branch(is_branch), .pc(pc),
  .set_val(set_val), .br_taken(br_taken), .next_pc(next_pc)
);

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa = '0, opb = '0, pc = '0;
  logic [15:0] imm = '0;
  logic [2:0]  cond = '0;
  logic        is_signed = 1'b0, use_imm = 1'b0, is_branch = 1'b0;
  logic [31:0] set_val, next_pc;
  logic        br_taken;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_branch_unit u_dut (
    .opa(opa), .opb(opb), .imm(imm), .cond(cond), .is_signed(is_signed),
    .use_imm(use_imm), .is_branch(is_branch), .pc(pc),
    .set_val(set_val), .br_taken(br_taken), .next_pc(next_pc)
  );

  function automatic bit model_rel(input logic [31:0] a, input logic [31:0] b,
                                   input logic [2:0] c, input bit sgn);
    longint la, lb;
    la = sgn ? longint'($signed(a)) : longint'({32'b0, a});
    lb = sgn ? longint'($signed(b)) : longint'({32'b0, b});
    case (c)
      3'd0: return la == lb;
      3'd1: return la != lb;
      3'd2: return la > lb;
      3'd3: return la >= lb;
      3'd4: return la < lb;
      3'd5: return la <= lb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [15:0] i,
                       input logic [2:0] c, input bit sgn, input bit ui, input bit br,
                       input logic [31:0] p, input string req);
    logic [31:0] rhs, exp_set, exp_pc;
    bit rel, exp_tk;
    @(posedge clk);
    #1;
    opa = a; opb = b; imm = i; cond = c; is_signed = sgn; use_imm = ui; is_branch = br; pc = p;
    if (ui && !br) rhs = sgn ? {{16{i[15]}}, i} : {16'b0, i};
    else rhs = b;
    rel = model_rel(a, rhs, c, sgn);
    exp_set = (rel && !br) ? 32'd1 : 32'd0;
    exp_tk = rel && br;
    exp_pc = p + 32'd4 + (exp_tk ? {{16{i[15]}}, i} : 32'd0);
    @(negedge clk);
    checks++;
    if (set_val !== exp_set || br_taken !== exp_tk || next_pc !== exp_pc) begin
      errors++;
      $display("FAIL %s: set_val=%h taken=%b next_pc=%h expected set_val=%h taken=%b next_pc=%h",
               req, set_val, br_taken, next_pc, exp_set, exp_tk, exp_pc);
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] sp [6] = '{32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h1, 32'h7FFF};
    if ($urandom_range(0, 2) == 0) return sp[$urandom_range(0, 5)];
    return $urandom();
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (set_val !== 32'd1 || br_taken !== 1'b0 || next_pc !== 32'd4) begin
      errors++;
      $display("FAIL R9 reset-state: set_val=%h taken=%b next_pc=%h expected 1 0 4",
               set_val, br_taken, next_pc);
    end

    for (int c = 0; c < 6; c++) begin
      for (int s = 0; s < 2; s++) begin
        apply(32'h7FFFFFFF, 32'h80000000, 16'h0, 3'(c), s[0], 1'b0, 1'b0, 32'h100, "R1 R2 max-vs-min");
        apply(32'h80000000, 32'h7FFFFFFF, 16'h0, 3'(c), s[0], 1'b0, 1'b0, 32'h100, "R1 R2 min-vs-max");
        apply(32'h0, 32'hFFFFFFFF, 16'h0, 3'(c), s[0], 1'b0, 1'b0, 32'h100, "R1 R2 zero-vs-ones");
        apply(32'h1234, 32'h1234, 16'h0, 3'(c), s[0], 1'b0, 1'b0, 32'h100, "R1 R3 equal pair");
      end
    end

    apply(32'hFFFFFFFF, 32'h0, 16'hFFFF, 3'd0, 1'b1, 1'b1, 1'b0, 32'h40, "R4 signed imm -1");
    apply(32'hFFFFFFFF, 32'h0, 16'hFFFF, 3'd0, 1'b0, 1'b1, 1'b0, 32'h40, "R4 unsigned imm zero-ext");
    apply(32'h0000FFFF, 32'h0, 16'hFFFF, 3'd0, 1'b0, 1'b1, 1'b0, 32'h40, "R4 unsigned imm match");
    apply(32'h0, 32'h0, 16'h8000, 3'd2, 1'b1, 1'b1, 1'b0, 32'h40, "R4 signed imm negative");

    apply(32'h5, 32'h9, 16'hFFF8, 3'd4, 1'b1, 1'b0, 1'b1, 32'h1000, "R5 taken backward");
    apply(32'h5, 32'h9, 16'h0010, 3'd4, 1'b1, 1'b0, 1'b1, 32'h1000, "R5 taken forward");
    apply(32'h5, 32'h5, 16'hFFF8, 3'd0, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFC, "R5 taken wrap");
    apply(32'h9, 32'h5, 16'hFFF8, 3'd4, 1'b1, 1'b0, 1'b1, 32'h1000, "R6 not taken");
    apply(32'h0, 32'h0, 16'h0, 3'd1, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFC, "R6 not taken wrap");
    apply(32'h3, 32'h7, 16'h0003, 3'd0, 1'b0, 1'b1, 1'b1, 32'h200, "R7 use_imm ignored in branch");
    apply(32'h7, 32'h7, 16'h0003, 3'd0, 1'b0, 1'b1, 1'b1, 32'h200, "R7 branch uses opb");
    apply(32'h1, 32'h1, 16'h0, 3'd6, 1'b0, 1'b0, 1'b0, 32'h300, "R8 code 6 compare");
    apply(32'h1, 32'h1, 16'h0, 3'd7, 1'b1, 1'b0, 1'b1, 32'h300, "R8 code 7 branch");

    for (int n = 0; n < 3000; n++) begin
      apply(pick(), pick(), 16'($urandom()), 3'($urandom_range(0, 7)), 1'($urandom()),
            1'($urandom()), 1'($urandom()), {$urandom()} & 32'hFFFFFFFC, "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule